// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic tick source for operating-system scheduling. A 24-bit counter counts down from a software-programmed reload value. When it steps from 1 to 0 it raises a sticky count flag and, if interrupts are enabled, pulses an interrupt request. On the next step it reloads, so the tick period is the reload value plus one count steps.

Each count step comes from one of two sources, chosen by a control bit. The first is every core clock cycle. The second is each rising edge of a slower reference clock, which the block brings into the core clock domain through a two-flop synchroniser and then edge-detects. Software reaches four word registers over a simple read/write bus: control/status, reload value, current value and a read-only calibration word. The calibration word is fixed by a parameter.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current registers read 0, the calibration register reads its parameter value, and irq is low.
- R2: Register index 0 is control/status, 1 is reload, 2 is current value and 3 is calibration. Read data appears on bus_rdata on the cycle after the cycle in which bus_rd is sampled high. In control/status, bit 0 is run enable, bit 1 is interrupt enable, bit 2 is source select (1 = core clock, 0 = reference clock) and bit 16 is the count flag. All other bits read 0.
- R3: Only the low 24 bits of the reload and current registers are held. Bits 31:24 of these registers always read 0.
- R4: When bit 2 is 1 and run enable is set, the counter takes one step on every core clock cycle. When run enable is clear, the counter holds its value.
- R5: A step taken at count 0 loads the reload value. Any other step decrements the count by one. With the counter started from 0, the 1-to-0 transition therefore recurs every reload+1 steps.
- R6: When bit 2 is 0, the counter steps once per rising edge of ref_clk, after a two-flop synchroniser. A reference level held steady produces no further steps.
- R7: The count flag sets on every 1-to-0 step. Reading control/status returns the flag and then clears it. If a 1-to-0 step falls in the same cycle as that read, the read returns the old flag and the flag stays set.
- R8: Any write to the current-value register clears the count to 0 and clears the count flag. The written data is discarded.
- R9: irq is high for exactly one cycle, the cycle after a 1-to-0 step, and only when interrupt enable is set.
- R10: With a reload value of 0, the counter stays at 0 and produces neither a flag nor an interrupt.
- R11: Writes to the calibration register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bench builds the block with the default 24-bit count width and 32-bit data width, plus a distinctive calibration word. With these values, masking of the upper register bits and the calibration readback are both visible at the ports. Because the reload value is a register rather than a parameter, the bench uses reload values of 0, 1 and 3 to reach the wrap and interrupt cadence within a few cycles, and a full 24-bit reload to exercise the counter at its top of range. Reference-clock pulses of a few cycles each make the synchroniser latency and the single step per edge observable in short runs.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_CUR  = 2'd2,
    REG_CAL  = 2'd3
  } tick_reg_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_INT_BIT  = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic src_core;
    logic int_en;
    logic run;
  } tick_ctrl_t;

  // Select the step source from the stored control fields.
  function automatic logic f_step(input tick_ctrl_t c, input logic ref_rise);
    return c.run & (c.src_core | ref_rise);
  endfunction

endpackage

// File: rtl/tick_refsync.sv
module tick_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_rise
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= ref_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_lvl <= 1'b0;
    else        last_lvl <= chain[STAGES-1];
  end

  assign ref_rise = chain[STAGES-1] & ~last_lvl;
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Reload at zero, otherwise decrement.
  function automatic logic [CNT_W-1:0] f_next_count(input logic [CNT_W-1:0] cur,
                                                    input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= f_next_count(count, reload_val);
  end

  assign hit = step & ~clear & (count == ONE);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int                CNT_W     = 24,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] CAL_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              hit,
  output tick_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              flag_q,
  output logic              cur_wr,
  output logic              ctrl_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CNT_W;

  tick_reg_e sel;
  logic      ctrl_wr, load_wr;
  logic      unused_wbits;

  assign sel          = tick_reg_e'(bus_addr);
  assign ctrl_wr      = bus_wr & (sel == REG_CTRL);
  assign load_wr      = bus_wr & (sel == REG_LOAD);
  assign cur_wr       = bus_wr & (sel == REG_CUR);
  assign ctrl_rd      = bus_rd & (sel == REG_CTRL);
  assign unused_wbits = ^bus_wdata;

  function automatic logic [DATA_W-1:0] f_ctrl_word(input tick_ctrl_t c, input logic f);
    logic [DATA_W-1:0] w;
    w                = '0;
    w[CTRL_RUN_BIT]  = c.run;
    w[CTRL_INT_BIT]  = c.int_en;
    w[CTRL_SRC_BIT]  = c.src_core;
    w[CTRL_FLAG_BIT] = f;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] f_read_word(input tick_reg_e s,
                                                    input tick_ctrl_t c,
                                                    input logic f,
                                                    input logic [CNT_W-1:0] rel,
                                                    input logic [CNT_W-1:0] cur);
    case (s)
      REG_CTRL: return f_ctrl_word(c, f);
      REG_LOAD: return {{PAD_W{1'b0}}, rel};
      REG_CUR:  return {{PAD_W{1'b0}}, cur};
      default:  return CAL_VALUE;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.run      <= bus_wdata[CTRL_RUN_BIT];
      ctrl_q.int_en   <= bus_wdata[CTRL_INT_BIT];
      ctrl_q.src_core <= bus_wdata[CTRL_SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reload_q <= '0;
    else if (load_wr) reload_q <= bus_wdata[CNT_W-1:0];
  end

  // A new wrap takes priority over a clear so that no tick is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (hit)              flag_q <= 1'b1;
    else if (ctrl_rd | cur_wr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= f_read_word(sel, ctrl_q, flag_q, reload_q, count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit & ctrl_q.int_en;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int                CNT_W       = 24,
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CAL_VALUE   = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  tick_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             ref_rise, step, hit, flag_q, cur_wr, ctrl_rd, int_en;

  assign step   = f_step(ctrl_q, ref_rise);
  assign int_en = ctrl_q.int_en;

  tick_refsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_in  (ref_clk),
    .ref_rise(ref_rise)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .clear     (cur_wr),
    .reload_val(reload_q),
    .count     (count),
    .hit       (hit)
  );

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CAL_VALUE(CAL_VALUE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .count    (count),
    .hit      (hit),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q),
    .flag_q   (flag_q),
    .cur_wr   (cur_wr),
    .ctrl_rd  (ctrl_rd),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              hit,
  input logic              cur_wr,
  input logic              flag_q,
  input logic              int_en,
  input logic              irq,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload_q,
  input logic [DATA_W-1:0] bus_rdata
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cur_wr && count != '0) |=> count == $past(count) - ONE);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cur_wr) |=> $stable(count));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cur_wr && count == '0) |=> count == $past(reload_q));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (count == '0 && !flag_q));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(hit && int_en));

  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r10_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && reload_q == '0) |=> count == '0);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=>
      bus_rdata[DATA_W-1:CNT_W] == '0);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .hit      (hit),
  .cur_wr   (cur_wr),
  .flag_q   (flag_q),
  .int_en   (int_en),
  .irq      (irq),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .count    (count),
  .reload_q (reload_q),
  .bus_rdata(bus_rdata)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  localparam logic [31:0] CAL = 32'hC000_1F40;
  localparam logic [1:0]  A_CTRL = 2'd0, A_LOAD = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;
  localparam logic [31:0] FLAG = 32'h0001_0000;

  logic        clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  tick_timer #(.CAL_VALUE(CAL)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic restart(input logic [31:0] rel, input logic [31:0] ctl);
    reg_wr(A_CTRL, 32'h0);
    reg_wr(A_LOAD, rel);
    reg_wr(A_CUR, 32'h0);
    reg_wr(A_CTRL, ctl);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    reg_rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
    reg_rd(A_LOAD, v); check("R1 reload reset", v, 32'h0);
    reg_rd(A_CUR, v);  check("R1 current reset", v, 32'h0);
    reg_rd(A_CAL, v);  check("R1 calibration reset", v, CAL);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    reg_wr(A_CTRL, 32'hFFFF_FFF8);
    reg_rd(A_CTRL, v); check("R2 ctrl undefined bits read 0", v, 32'h0);
    reg_wr(A_CTRL, 32'h6);
    reg_rd(A_CTRL, v); check("R2 ctrl fields read back", v, 32'h6);
    reg_wr(A_CTRL, 32'h0);
    reg_wr(A_LOAD, 32'hFFFF_FFFF);
    reg_rd(A_LOAD, v); check("R3 reload upper bits 0", v, 32'h00FF_FFFF);
    reg_wr(A_CAL, 32'h0);
    reg_rd(A_CAL, v); check("R11 calibration write ignored", v, CAL);
  endtask

  // Core clock counting: value after a known number of enabled cycles.
  task automatic t_core_count(input logic [31:0] rel, input int n);
    logic [31:0] v;
    restart(rel, 32'h5);
    repeat (n) @(negedge clk);
    reg_wr(A_CTRL, 32'h0);
    reg_rd(A_CUR, v);
    check("R4 core clock count value", v, rel - 32'(n) - 32'd1);
    repeat (5) @(negedge clk);
    reg_rd(A_CUR, v);
    check("R4 disabled counter holds", v, rel - 32'(n) - 32'd1);
  endtask

  // Interrupt cadence every reload+1 cycles, then flag read and clear.
  task automatic t_irq_period(input logic [31:0] rel);
    logic [31:0] v;
    int bad = 0;
    restart(rel, 32'h7);
    for (int i = 1; i <= 3 * (int'(rel) + 1); i++) begin
      @(negedge clk);
      if (irq !== ((i % (int'(rel) + 1)) == 0)) bad++;
    end
    check($sformatf("R5 R9 irq cadence reload=%0d", rel), 32'(bad), 32'h0);
    reg_wr(A_CTRL, 32'h0);
    reg_rd(A_CTRL, v); check("R7 flag reads set", v, FLAG);
    reg_rd(A_CTRL, v); check("R7 flag cleared by read", v, 32'h0);
  endtask

  task automatic t_irq_masked;
    logic [31:0] v;
    int bad = 0;
    restart(32'd3, 32'h5);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (irq !== 1'b0) bad++;
    end
    check("R9 no irq with interrupt enable clear", 32'(bad), 32'h0);
    reg_wr(A_CTRL, 32'h0);
    reg_rd(A_CTRL, v); check("R7 flag set without irq", v, FLAG);
  endtask

  // Read of control/status in the very cycle of a wrap.
  task automatic t_flag_race;
    logic [31:0] v;
    restart(32'd3, 32'h5);
    repeat (2) @(negedge clk);
    reg_rd(A_CTRL, v);
    check("R7 read coincident with wrap returns old flag", v, 32'h5);
    reg_wr(A_CTRL, 32'h0);
    reg_rd(A_CTRL, v);
    check("R7 flag survives coincident read", v, FLAG);
  endtask

  task automatic t_cur_write;
    logic [31:0] v;
    restart(32'd2, 32'h5);
    repeat (10) @(negedge clk);
    reg_wr(A_CTRL, 32'h0);
    reg_wr(A_CUR, 32'h00AB_CDEF);
    reg_rd(A_CUR, v);  check("R8 current write clears count", v, 32'h0);
    reg_rd(A_CTRL, v); check("R8 current write clears flag", v, 32'h0);
  endtask

  task automatic t_zero_reload;
    logic [31:0] v;
    int bad = 0;
    restart(32'd0, 32'h7);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (irq !== 1'b0) bad++;
    end
    check("R10 no irq with reload 0", 32'(bad), 32'h0);
    reg_rd(A_CUR, v);  check("R10 count stays 0", v, 32'h0);
    reg_rd(A_CTRL, v); check("R10 no flag with reload 0", v, 32'h7);
    reg_wr(A_CTRL, 32'h0);
  endtask

  task automatic ref_pulse(input int hi, input int lo);
    @(negedge clk); ref_clk = 1'b1;
    repeat (hi) @(negedge clk);
    ref_clk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_ref_source;
    logic [31:0] v;
    restart(32'd50, 32'h1);
    repeat (10) @(negedge clk);
    reg_rd(A_CUR, v); check("R6 no steps without reference edges", v, 32'h0);
    for (int p = 0; p < 5; p++) ref_pulse(3, 3);
    repeat (4) @(negedge clk);
    reg_rd(A_CUR, v); check("R6 one step per reference edge", v, 32'd46);
    @(negedge clk); ref_clk = 1'b1;
    repeat (20) @(negedge clk);
    ref_clk = 1'b0;
    repeat (4) @(negedge clk);
    reg_rd(A_CUR, v); check("R6 held level gives single step", v, 32'd45);
    reg_wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_core_count(32'd100, 10);
    t_core_count(32'h00FF_FFFF, 10);
    t_irq_period(32'd3);
    t_irq_period(32'd1);
    t_irq_masked;
    t_flag_race;
    t_cur_write;
    t_zero_reload;
    t_ref_source;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule